// File: doc/BRIEF.md
# ALU Arithmetic Status Flag Unit

This block is a parameterised-width arithmetic and logic unit with a registered status word. The status word holds four flags: negative, zero, carry and signed overflow. The result is purely combinational from the two operands and the operation code. The flags are computed alongside the result and are written into the status register on a clock edge, but only when the update strobe is high. The same flags come out of every operation, so one operation serves both signed and unsigned data. Software or a sequencer reads whichever flag suits its interpretation.

Each class of operation has its own overflow rule. Add and subtract report the XOR of the carry into the sign bit and the carry out of it. The bitwise operations force overflow to zero, so a clear overflow flag shows that the negative flag is a true sign. The one-bit left shift reports overflow when the sign bit changes. A trap output can be enabled; it pulses for one cycle when an add or subtract writes a set overflow flag.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation code 0 (add) gives result = (A + B) mod 2^WIDTH, and the carry flag loads the carry out of the top bit.
- R2: Operation code 1 (subtract) gives result = (A - B) mod 2^WIDTH, computed as A + ~B + 1. The carry flag loads 1 when no borrow occurs, that is, when A >= B taken as unsigned.
- R3: On add and subtract, the overflow flag loads 1 exactly when the signed two's-complement result falls outside the representable range. Consequences: an add of operands with different signs, or a subtract of operands with equal signs, always loads 0. At 8 bits, 0x7F + 0x7F gives 0xFE with overflow 1.
- R4: Operation codes 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and NOT A. Each of them loads 0 into the overflow flag and leaves the carry flag unchanged.
- R5: Operation code 6 gives A shifted left by one with a 0 filled into bit 0. The carry flag loads the old bit WIDTH-1, and the overflow flag loads old bit WIDTH-1 XOR old bit WIDTH-2.
- R6: On every valid operation, the negative flag loads bit WIDTH-1 of the result. The zero flag loads 1 exactly when every result bit is 0.
- R7: The flags change only on a rising clock edge where the update strobe is high. When the strobe is low, all four flags hold their values.
- R8: A synchronous active-low reset clears all four flags and the trap output. Reset takes priority over a strobe at the same edge.
- R9: The trap output is high for the one cycle after an edge where the trap enable, the update strobe, an add or subtract code and a computed overflow of 1 all coincide. It never rises for other codes.
- R10: Operation code 7 is reserved. It gives a result of 0 and leaves all four flags unchanged even when the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 not A, 6 shift left, 7 reserved) |
| upd | input | 1 | Flag update strobe |
| trap_en | input | 1 | Enables the overflow trap |
| result | output | WIDTH | Combinational operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Signed overflow flag |
| trap | output | 1 | One-cycle overflow trap pulse |

## Verification
The flag write and the trap pulse come from the same edge, so a wrong overflow value or a wrong gating term shows up in both places at once. The sweep covers every operand pair and every operation code at a width of 4. The trap enable and the strobe are toggled by patterns that do not follow the operands. After each edge, both the flags and the trap are compared against an arithmetic model that uses signed range checks rather than carry logic. A separate case asserts reset on the same edge as an overflowing add with trapping enabled, and expects cleared flags and no trap.

// File: rtl/alu_flag_pkg.sv
// Package: operation codes and the status word layout shared by the ALU blocks.
// Assumes: 3-bit operation codes; code 7 is reserved.
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_NOT = 3'd5,
        OP_SHL = 3'd6,
        OP_RSV = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu_adder.sv
// Module: add/subtract core. It returns the sum, the carry out of the top bit
// and the carry into the top bit, so that signed overflow can be formed.
// Assumes: WIDTH >= 2. Subtraction is A + ~B + 1.
module alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             carry_msb_in
);
    localparam int LOW = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [LOW-1:0]   low_sum;
    logic             msb_sum;

    // Invert the second operand for subtraction.
    assign b_eff = sub ? ~b : b;

    // Lower bits, keeping the carry that enters the sign bit.
    assign {carry_msb_in, low_sum} = {1'b0, a[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]}
                                     + {{LOW{1'b0}}, sub};

    // Sign bit stage.
    assign {carry_out, msb_sum} = {1'b0, a[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]}
                                  + {1'b0, carry_msb_in};

    assign sum = {msb_sum, low_sum};
endmodule

// File: rtl/alu_datapath.sv
// Module: combinational result and next-flag logic for all operation codes.
// Assumes: WIDTH >= 2. Bitwise operations keep the previous carry. The
// reserved code yields zero and deasserts 'load'.
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    input  logic             carry_prev,
    output logic [WIDTH-1:0] res,
    output alu_flags_t       nxt,
    output logic             load,
    output logic             arith
);
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             cmsb;

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a            (a),
        .b            (b),
        .sub          (op == OP_SUB),
        .sum          (sum),
        .carry_out    (cout),
        .carry_msb_in (cmsb)
    );

    // Select the result, carry and overflow for each operation class.
    always_comb begin
        res   = '0;
        nxt.c = carry_prev;
        nxt.v = 1'b0;
        load  = 1'b1;
        arith = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                res   = sum;
                nxt.c = cout;
                nxt.v = cout ^ cmsb;
                arith = 1'b1;
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: begin
                res   = {a[WIDTH-2:0], 1'b0};
                nxt.c = a[WIDTH-1];
                nxt.v = a[WIDTH-1] ^ a[WIDTH-2];
            end
            default: load = 1'b0;
        endcase
        nxt.n = res[WIDTH-1];
        nxt.z = ~|res;
    end
endmodule

// File: rtl/alu_status_reg.sv
// Module: status flag register and overflow trap pulse.
// Assumes: synchronous active-low reset; flags load only on strobe with a
// valid operation.
module alu_status_reg
    import alu_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       load,
    input  logic       arith,
    input  logic       trap_en,
    input  alu_flags_t nxt,
    output alu_flags_t flags,
    output logic       trap
);
    // Hold or load the status word; raise the trap for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            trap  <= 1'b0;
        end else begin
            if (upd && load) begin
                flags <= nxt;
            end
            trap <= trap_en && upd && arith && nxt.v;
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
// Module: top of the ALU with its registered N/Z/C/V status word and trap.
// Assumes: WIDTH >= 2; op_sel uses the codes of alu_flag_pkg.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       op_sel,
    input  logic             upd,
    input  logic             trap_en,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v,
    output logic             trap
);
    localparam int MSB = WIDTH - 1;

    alu_flags_t nxt;
    alu_flags_t flags;
    logic       load;
    logic       arith;

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .a          (op_a),
        .b          (op_b),
        .op         (alu_op_e'(op_sel)),
        .carry_prev (flags.c),
        .res        (result),
        .nxt        (nxt),
        .load       (load),
        .arith      (arith)
    );

    alu_status_reg u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .load    (load),
        .arith   (arith),
        .trap_en (trap_en),
        .nxt     (nxt),
        .flags   (flags),
        .trap    (trap)
    );

    assign flag_n = flags.n;
    assign flag_z = flags.z;
    assign flag_c = flags.c;
    assign flag_v = flags.v;

    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    a_r3_add_mixed_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel == 3'd0 && op_a[MSB] != op_b[MSB]) |=> !flag_v);

    a_r3_sub_equal_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel == 3'd1 && op_a[MSB] == op_b[MSB]) |=> !flag_v);

    a_r4_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel >= 3'd2 && op_sel <= 3'd5) |=> (!flag_v && $stable(flag_c)));

    a_r6_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel != 3'd7) |=> (flag_z == ($past(result) == '0)));

    a_r9_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(trap_en && upd && op_sel <= 3'd1));

    a_r10_reserved_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && op_sel == 3'd7) |=> $stable({flag_n, flag_z, flag_c, flag_v}));
endmodule

// File: tb/alu_flag_unit_test.sv
// Bench: exhaustive sweep of a 4-bit instance against an arithmetic model.
module alu_flag_unit_test;
    localparam int W    = 4;
    localparam int SPAN = 1 << W;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] op_a, op_b;
    logic [2:0]   op_sel;
    logic         upd, trap_en;
    logic [W-1:0] result;
    logic         flag_n, flag_z, flag_c, flag_v, trap;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    int e_n = 0, e_z = 0, e_c = 0, e_v = 0;

    always #10 clk = ~clk;

    alu_flag_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .upd(upd), .trap_en(trap_en), .result(result), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .trap(trap)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int to_signed(input int u);
        return (u > SMAX) ? u - SPAN : u;
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; op_a = '0; op_b = '0; op_sel = 3'd0; upd = 1'b0; trap_en = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check("R8", "reset flags", int'({flag_n, flag_z, flag_c, flag_v}), 0);
        check("R8", "reset trap", int'(trap), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < SPAN; a++) begin
                for (int b = 0; b < SPAN; b++) begin
                    int    r, c, v, full;
                    bit    valid, st;
                    string rt, ct, vt, nzt;
                    @(negedge clk);
                    op_a = W'(a); op_b = W'(b); op_sel = 3'(op);
                    st = ((a * 3 + b + op) % 4) != 0;
                    upd = st;
                    trap_en = ((a + b) % 2) == 1;
                    valid = 1'b1; c = e_c; v = 0; r = 0;
                    case (op)
                        0: begin full = a + b; r = full % SPAN; c = full / SPAN;
                               full = to_signed(a) + to_signed(b);
                               v = (full > SMAX || full < SMIN); rt = "R1"; ct = "R1"; vt = "R3"; end
                        1: begin r = (a - b + SPAN) % SPAN; c = (a >= b);
                               full = to_signed(a) - to_signed(b);
                               v = (full > SMAX || full < SMIN); rt = "R2"; ct = "R2"; vt = "R3"; end
                        2: begin r = a & b; rt = "R4"; ct = "R4"; vt = "R4"; end
                        3: begin r = a | b; rt = "R4"; ct = "R4"; vt = "R4"; end
                        4: begin r = a ^ b; rt = "R4"; ct = "R4"; vt = "R4"; end
                        5: begin r = (SPAN - 1) - a; rt = "R4"; ct = "R4"; vt = "R4"; end
                        6: begin r = (a * 2) % SPAN; c = a / (SPAN / 2);
                               full = to_signed(a) * 2;
                               v = (full > SMAX || full < SMIN); rt = "R5"; ct = "R5"; vt = "R5"; end
                        default: begin valid = 1'b0; rt = "R10"; ct = "R10"; vt = "R10"; end
                    endcase
                    nzt = valid ? "R6" : "R10";
                    if (!st) begin ct = "R7"; vt = "R7"; nzt = "R7"; end
                    #2;
                    check(rt, "result", int'(result), r);
                    @(posedge clk);
                    #5;
                    if (st && valid) begin
                        e_n = r / (SPAN / 2); e_z = (r == 0); e_c = c; e_v = v;
                    end
                    check(nzt, "flag_n", int'(flag_n), e_n);
                    check(nzt, "flag_z", int'(flag_z), e_z);
                    check(ct,  "flag_c", int'(flag_c), e_c);
                    check(vt,  "flag_v", int'(flag_v), e_v);
                    check("R9", "trap", int'(trap), int'(trap_en && st && op < 2 && v != 0));
                end
            end
        end

        // R9: pulse lasts one cycle when the next operation does not overflow.
        @(negedge clk);
        op_a = 4'h7; op_b = 4'h7; op_sel = 3'd0; upd = 1'b1; trap_en = 1'b1;
        @(posedge clk); #5;
        check("R3", "0x7+0x7 overflow", int'(flag_v), 1);
        check("R9", "trap raised", int'(trap), 1);
        @(negedge clk);
        op_sel = 3'd2;
        @(posedge clk); #5;
        check("R9", "trap single cycle", int'(trap), 0);

        // R8: reset wins over an overflowing strobed add at the same edge.
        @(negedge clk);
        op_sel = 3'd0; rst_n = 1'b0;
        @(posedge clk); #5;
        check("R8", "reset over strobe flags", int'({flag_n, flag_z, flag_c, flag_v}), 0);
        check("R8", "reset over strobe trap", int'(trap), 0);
        @(negedge clk);
        rst_n = 1'b1; upd = 1'b0;

        done = 1'b1;
        report();
    end
endmodule